// File: doc/BRIEF.md
# Multi-Waveform Direct Digital Synthesizer

The block is a direct digital synthesis core that produces a 12-bit sample stream on every clock. A 32-bit phase register advances by a caller-supplied tuning word each cycle, so the output repeats once every 2^32 / tuning-word cycles. The upper phase bits are turned into one of four 8-bit raw shapes: sine (from a 64-point table held as constants inside the block), rectangular, triangular or sawtooth. A 5-bit gain then scales that raw value down to the 12-bit sample.

The block has four operating modes, one per waveform kind: WAVE_SINE (code 0), WAVE_RECT (code 1), WAVE_TRI (code 2) and WAVE_SAW (code 3). Any mode can move to any other mode by changing the select input; the move is seen on the next registered sample. There is no other sequencing. Tuning word and gain can also change while the block runs, and the new values act on the next sample. The registered mode code is also driven out for a status display.

Top module: `dds_wavegen`

## Requirements
- R1: While `rst_n` is low, `sample` and `wave_code` are 0 and the phase register is cleared, so the first sample after reset comes from phase 0.
- R2: On every clock out of reset the phase register takes (phase + `tune_word`) modulo 2^32.
- R3: With select 0 the raw value is table entry k = phase[31:26], where entry k equals floor(128 + 127*sin(2*pi*k/64) + 0.5).
- R4: With select 1 the raw value is 255 while phase[31] is 0 and 0 while phase[31] is 1.
- R5: With select 2 the raw value is phase[30:23] while phase[31] is 0 and the bitwise inverse of phase[30:23] while phase[31] is 1.
- R6: With select 3 the raw value is phase[31:24].
- R7: The sample is bits [12:1] of the 13-bit product raw times `amp`, so a gain of 0 gives a sample of 0 and no sample exceeds floor(255*amp/2).
- R8: The sample is registered: the value present after a clock edge is computed from the phase, select and gain that were present before that edge.
- R9: `wave_code` is a registered copy of `wave_sel` with the same one-clock delay as the sample.
- R10: Select, tuning word and gain may change at any cycle without reset; a tuning word of 0 with steady select and gain holds the sample constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wave_sel | input | 2 | Waveform select: 0 sine, 1 rectangular, 2 triangular, 3 sawtooth |
| tune_word | input | 32 | Phase increment added every clock |
| amp | input | 5 | Gain applied to the raw shape |
| sample | output | 12 | Registered scaled sample |
| wave_code | output | 2 | Registered waveform code for display |

## Verification
The properties assume that select, tuning word and gain are known values once reset is released and that they settle between clock edges, since each property compares the sample with inputs seen one edge earlier. The bench changes inputs one time unit after each rising edge and never leaves them undriven, and it raises reset in the same position, so every edge sees stable inputs. The hold property additionally relies on the tuning word staying at zero for the cycle in question, which the bench provides in a dedicated segment of steady select and gain.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [1:0] {
        WAVE_SINE = 2'd0,
        WAVE_RECT = 2'd1,
        WAVE_TRI  = 2'd2,
        WAVE_SAW  = 2'd3
    } wave_kind_e;

    // One point of a full-period sine centred on 'mid', peak offset mid-1.
    function automatic int sine_point(input int idx, input int depth, input int mid);
        real ang;
        real val;
        ang = 6.283185307179586 * real'(idx) / real'(depth);
        val = real'(mid) + real'(mid - 1) * $sin(ang) + 0.5;
        return $rtoi(val);
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int PHASE_W = 32,
    parameter int TAP_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tune,
    output logic [TAP_W-1:0]   phase_top
);
    logic [PHASE_W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + tune;
        end
    end

    assign phase_top = acc_q[PHASE_W-1 -: TAP_W];
endmodule

// File: rtl/dds_shape_gen.sv
module dds_shape_gen
    import dds_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int RAW_W  = 8
) (
    input  logic [RAW_W:0]   phase_top,
    input  wave_kind_e       kind,
    output logic [RAW_W-1:0] raw
);
    localparam int DEPTH = 2 ** ADDR_W;
    localparam int MID   = 2 ** (RAW_W - 1);

    logic [RAW_W-1:0]  sine_rom [DEPTH];
    logic [ADDR_W-1:0] rom_addr;
    logic              half_sel;
    logic [RAW_W-1:0]  ramp_val;
    logic [RAW_W-1:0]  fold_val;

    for (genvar k = 0; k < DEPTH; k++) begin : g_sine
        localparam int PT = sine_point(k, DEPTH, MID);
        assign sine_rom[k] = RAW_W'(PT);
    end

    assign half_sel = phase_top[RAW_W];
    assign rom_addr = phase_top[RAW_W -: ADDR_W];
    assign ramp_val = phase_top[RAW_W -: RAW_W];
    assign fold_val = half_sel ? ~phase_top[RAW_W-1:0] : phase_top[RAW_W-1:0];

    always_comb begin
        unique case (kind)
            WAVE_SINE: raw = sine_rom[rom_addr];
            WAVE_RECT: raw = {RAW_W{~half_sel}};
            WAVE_TRI:  raw = fold_val;
            WAVE_SAW:  raw = ramp_val;
            default:   raw = '0;
        endcase
    end
endmodule

// File: rtl/dds_scaler.sv
module dds_scaler
    import dds_pkg::*;
#(
    parameter int RAW_W = 8,
    parameter int AMP_W = 5,
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RAW_W-1:0] raw,
    input  logic [AMP_W-1:0] gain,
    input  wave_kind_e       kind,
    output logic [OUT_W-1:0] sample,
    output wave_kind_e       code
);
    localparam int PROD_W = RAW_W + AMP_W;
    localparam int SHIFT  = PROD_W - OUT_W;

    logic [PROD_W-1:0] product;

    assign product = PROD_W'(raw) * PROD_W'(gain);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample <= '0;
            code   <= WAVE_SINE;
        end else begin
            sample <= OUT_W'(product >> SHIFT);
            code   <= kind;
        end
    end
endmodule

// File: rtl/dds_wavegen.sv
module dds_wavegen
    import dds_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 6,
    parameter int RAW_W   = 8,
    parameter int AMP_W   = 5,
    parameter int OUT_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         wave_sel,
    input  logic [PHASE_W-1:0] tune_word,
    input  logic [AMP_W-1:0]   amp,
    output logic [OUT_W-1:0]   sample,
    output logic [1:0]         wave_code
);
    localparam int TAP_W = RAW_W + 1;

    logic [TAP_W-1:0] phase_top;
    logic [RAW_W-1:0] raw;
    wave_kind_e       kind;
    wave_kind_e       code;

    assign kind      = wave_kind_e'(wave_sel);
    assign wave_code = code;

    dds_phase_acc #(.PHASE_W(PHASE_W), .TAP_W(TAP_W)) i_acc (
        .clk(clk), .rst_n(rst_n), .tune(tune_word), .phase_top(phase_top)
    );

    dds_shape_gen #(.ADDR_W(ADDR_W), .RAW_W(RAW_W)) i_shape (
        .phase_top(phase_top), .kind(kind), .raw(raw)
    );

    dds_scaler #(.RAW_W(RAW_W), .AMP_W(AMP_W), .OUT_W(OUT_W)) i_scale (
        .clk(clk), .rst_n(rst_n), .raw(raw), .gain(amp), .kind(kind),
        .sample(sample), .code(code)
    );
endmodule

// File: rtl/dds_wavegen_checker.sv
module dds_wavegen_checker #(
    parameter int PHASE_W = 32,
    parameter int AMP_W   = 5,
    parameter int OUT_W   = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         wave_sel,
    input logic [PHASE_W-1:0] tune_word,
    input logic [AMP_W-1:0]   amp,
    input logic [OUT_W-1:0]   sample,
    input logic [1:0]         wave_code
);
    localparam int RECT_TOP = (255 * (2 ** AMP_W - 1)) / 2;

    // R7: zero gain silences the next sample
    p_amp_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (amp == '0) |=> (sample == '0));

    // R7: sample never exceeds the scaled full-scale raw value
    p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(sample) <= (255 * int'($past(amp))) / 2));

    // R9: display code lags the select by one clock
    p_code_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wave_code == $past(wave_sel)));

    // R4: rectangular at full gain takes only its two levels
    p_rect_levels_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_sel == 2'd1 && amp == '1) |=> (sample == '0 || int'(sample) == RECT_TOP));

    // R10: zero tuning word with steady select and gain holds the sample
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tune_word) == '0 &&
         wave_sel == $past(wave_sel) && amp == $past(amp)) |=> $stable(sample));
endmodule

bind dds_wavegen dds_wavegen_checker #(
    .PHASE_W(PHASE_W), .AMP_W(AMP_W), .OUT_W(OUT_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .wave_sel(wave_sel), .tune_word(tune_word),
    .amp(amp), .sample(sample), .wave_code(wave_code)
);

// File: tb/test_dds_wavegen.sv
`timescale 1ns/1ps
module test_dds_wavegen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  wave_sel;
    logic [31:0] tune_word;
    logic [4:0]  amp;
    logic [11:0] sample;
    logic [1:0]  wave_code;

    int checks = 0;
    int fails  = 0;
    longint unsigned ph = 0;
    string shape_tag [4] = '{"R3", "R4", "R5", "R6"};

    always #2.5 clk = ~clk;

    dds_wavegen i_dds_wavegen (
        .clk(clk), .rst_n(rst_n), .wave_sel(wave_sel), .tune_word(tune_word),
        .amp(amp), .sample(sample), .wave_code(wave_code)
    );

    function automatic int ref_raw(longint unsigned p, int sel);
        int idx;
        int half;
        int low8;
        half = int'((p >> 31) & 1);
        case (sel)
            0: begin
                idx = int'((p >> 26) & 63);
                return $rtoi(128.0 + 127.0 * $sin(6.283185307179586 * idx / 64.0) + 0.5);
            end
            1: return half ? 0 : 255;
            2: begin
                low8 = int'((p >> 23) & 255);
                return half ? 255 - low8 : low8;
            end
            default: return int'((p >> 24) & 255);
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, let the edge pass, compare with the model.
    task automatic step(int sel, longint unsigned tw, int am, string note);
        int exp;
        wave_sel  = 2'(sel);
        tune_word = 32'(tw);
        amp       = 5'(am);
        @(posedge clk);
        #1;
        exp = (ref_raw(ph, sel) * am) / 2;        // R7 scaling, R8 latency
        ph  = (ph + tw) & 64'hFFFF_FFFF;          // R2 wrap
        check({note, shape_tag[sel], "/R7/R8"}, int'(sample), exp);
        check({note, "R9"}, int'(wave_code), sel);
    endtask

    task automatic do_reset(int cycles);
        rst_n = 1'b0;
        #1;
        check("R1 sample", int'(sample), 0);
        check("R1 code", int'(wave_code), 0);
        repeat (cycles) @(posedge clk);
        #1;
        check("R1 sample held", int'(sample), 0);
        rst_n = 1'b1;
        ph = 0;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wave_sel = 2'd0; tune_word = '0; amp = '0;
        @(posedge clk);
        #1;
        do_reset(3);
        // R1: first sample from phase 0, sine entry 0 = 128
        step(0, 64'h0400_0000, 31, "R1 ");
        // R3: walk every table entry, past a full period
        for (int i = 0; i < 70; i++) step(0, 64'h0400_0000, 31, "");
        for (int i = 0; i < 60; i++) step(1, 64'h0300_0000, 31, "");
        for (int i = 0; i < 200; i++) step(2, 64'h0123_4567, 17, "");
        for (int i = 0; i < 300; i++) step(3, 64'h00F0_0000, 9, "");
        // R7: gain sweep including 0, R10 gain changes on the fly
        for (int a = 0; a < 32; a++)
            for (int i = 0; i < 8; i++) step(3, 64'h0800_0000, a, "R10 ");
        // R10: zero tuning word holds the output
        for (int i = 0; i < 20; i++) step(0, 64'h0, 20, "R10 ");
        // R2: largest increment, wraps on every clock
        for (int i = 0; i < 40; i++) step(2, 64'hFFFF_FFFF, 31, "R2 ");
        // R10: select, tuning word and gain all changing each clock
        for (int i = 0; i < 400; i++)
            step(i % 4, (longint'(i) * 64'h0135_7913) & 64'hFFFF_FFFF, (i * 7) % 32, "R10 ");
        // R1: reset in mid-run clears phase and outputs
        @(negedge clk);
        do_reset(2);
        step(1, 64'h8000_0000, 31, "R1 ");
        step(1, 64'h8000_0000, 31, "R1 ");
        for (int i = 0; i < 20; i++) step(0, 64'h0200_0000, 15, "");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule